// File: doc/BRIEF.md
# Priority Hit-Selection Pixel Column

This block is the digital periphery of a single column in a hit-detecting pixel array. Each of its readout cells watches its own hit line, which is asynchronous to the readout clock. When a hit arrives, the cell raises a flag and keeps a copy of the global time-stamp counter.

A fixed-priority chain looks at every cell at once. It presents the address and time stamp of the winning pending hit as one word, together with a valid flag, so that the end-of-column stage can take it in a single clock cycle. When that stage strobes load, only the winning cell is emptied. Every other pending hit waits for a later readout loop. The block has no trigger, no buffering and no zero suppression.

Top module: `hit_column`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears every hit flag, stored time stamp and synchroniser stage; while no flag is set, out_valid is 0 and out_word is all zeros.
- R2: A hit is the rising edge of hit_in[i] (high for at least one clock). Cell i becomes flagged at the third rising clock edge after hit_in[i] rises and stores the ts_in value sampled at that same edge; out_valid is still 0 after the second edge.
- R3: When several cells are flagged, the cell with the lowest index is selected.
- R4: out_word[15:8] holds the selected cell index zero-extended to 8 bits, and out_word[7:0] holds that cell's stored time stamp; out_valid is 1 exactly when at least one cell is flagged.
- R5: A clock edge with load high clears the flag of the selected cell only; all other flagged cells keep their flags and time stamps.
- R6: A new hit on a cell that is already flagged is ignored; the stored time stamp stays unchanged.
- R7: A load while no cell is flagged has no effect; the outputs stay at zero.
- R8: A hit line held high flags its cell once only; after that cell is cleared it stays clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | 40 | Raw per-cell hit lines, asynchronous |
| ts_in | input | 8 | Global time-stamp counter value |
| load | input | 1 | End-of-column capture strobe; clears the selected hit |
| out_valid | output | 1 | At least one cell holds a hit |
| out_word | output | 16 | Selected address (upper byte) and time stamp (lower byte) |

## Verification
The assertions assume that every hit pulse stays high for at least one full clock period, so that the synchronisers see it. They also assume that load is a clean synchronous strobe, which the end-of-column stage gives the column. The stimulus changes hit_in and load only on falling clock edges and holds each pulse across at least one rising edge. The time-stamp counter advances on rising edges, so the captured value is set by the edge that sets the flag. Cells that already hold a flag are hit again on purpose, to check that the ignore rule works, but never in the same cycle as a load that targets them.

// File: rtl/hit_column.sv
module hit_column #(
  parameter int N_CELLS = 40,
  parameter int TS_W    = 8,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = $clog2(N_CELLS),
  localparam int WORD_W = ADDR_W + TS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] hit_in,
  input  logic [TS_W-1:0]    ts_in,
  input  logic               load,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word
);

  logic [N_CELLS-1:0] sync_a, sync_b, sync_c, flag, rise;
  logic [TS_W-1:0]    ts_mem [N_CELLS];
  logic [IDX_W-1:0]   sel;

  assign rise      = sync_b & ~sync_c;
  assign out_valid = |flag;

  always_comb begin
    sel = '0;
    for (int i = N_CELLS - 1; i >= 0; i--)
      if (flag[i]) sel = IDX_W'(i);
  end

  assign out_word = out_valid ? {ADDR_W'(sel), ts_mem[sel]} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
      flag   <= '0;
      for (int i = 0; i < N_CELLS; i++) ts_mem[i] <= '0;
    end else begin
      sync_a <= hit_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
      for (int i = 0; i < N_CELLS; i++) begin
        if (load && out_valid && sel == IDX_W'(i))
          flag[i] <= 1'b0;
        else if (rise[i] && !flag[i]) begin
          flag[i]   <= 1'b1;
          ts_mem[i] <= ts_in;
        end
      end
    end
  end

  a_r1_reset_empty: assert property (@(posedge clk) rst |=> !out_valid);

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag[sel] &&
      ((flag & ((N_CELLS'(1) << sel) - N_CELLS'(1))) == '0)));

  for (genvar g = 0; g < N_CELLS; g++) begin : g_chk
    a_r2_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[g]) |-> $past(rise[g]));

    a_r5_clear_selected: assert property (@(posedge clk) disable iff (rst)
      (load && out_valid && sel == IDX_W'(g)) |=> !flag[g]);

    a_r6_hold_pending: assert property (@(posedge clk) disable iff (rst)
      (flag[g] && !(load && sel == IDX_W'(g))) |=> (flag[g] && $stable(ts_mem[g])));
  end

endmodule

// File: tb/hit_column_bench.sv
module hit_column_bench;
  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  hit_in = '0;
  logic [7:0]    ts_in = '0;
  logic          load = 1'b0;
  logic          out_valid;
  logic [15:0]   out_word;

  hit_column u_hit_column (
    .clk(clk), .rst(rst), .hit_in(hit_in), .ts_in(ts_in),
    .load(load), .out_valid(out_valid), .out_word(out_word)
  );

  always #4 clk = ~clk;
  always @(posedge clk) ts_in <= ts_in + 8'd1;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [16:0] expq[$];
  bit         mflag [N];
  logic [7:0] mts   [N];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin mflag[i] = 0; mts[i] = '0; end
  endtask

  task automatic pulse(logic [N-1:0] m);
    logic [7:0] v;
    @(negedge clk);
    v = ts_in;
    hit_in = m;
    @(negedge clk);
    hit_in = '0;
    for (int i = 0; i < N; i++)
      if (m[i] && !mflag[i]) begin mflag[i] = 1; mts[i] = v + 8'd2; end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_load();
    int w;
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (mflag[i]) w = i;
    if (w >= 0) begin
      expq.push_back({1'b1, 8'(w), mts[w]});
      mflag[w] = 0;
    end else expq.push_back(17'h0);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  initial begin : monitor
    logic [16:0] e;
    forever begin
      @(negedge clk); #2;
      if (load) begin
        if (expq.size() == 0) check("R5 scoreboard underflow", 1, 0);
        else begin
          e = expq.pop_front();
          check("R3 R4 R5 R7 word at load", {15'd0, out_valid, out_word}, {15'd0, e});
        end
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] v;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 reset valid", {31'd0, out_valid}, 0);
    check("R1 reset word", {16'd0, out_word}, 0);

    // R2 latency and time-stamp capture
    @(negedge clk);
    v = ts_in;
    hit_in[5] = 1'b1;
    @(negedge clk);
    hit_in = '0;
    @(negedge clk); #2;
    check("R2 not flagged after two edges", {31'd0, out_valid}, 0);
    @(negedge clk); #2;
    check("R2 flagged after third edge", {15'd0, out_valid, out_word}, {15'd0, 1'b1, 8'd5, 8'(v + 8'd2)});
    mflag[5] = 1; mts[5] = v + 8'd2;
    do_load();
    #2;
    check("R4 empty word zero", {15'd0, out_valid, out_word}, 0);

    // R3 priority across several pending hits, including the end cells
    pulse((N'(1) << 39) | (N'(1) << 7) | (N'(1) << 2) | N'(1));
    do_load(); do_load(); do_load(); do_load();
    // R7 load on an empty column
    do_load();
    #2;
    check("R7 still empty", {15'd0, out_valid, out_word}, 0);

    // R6 repeat hit on flagged cell ignored
    pulse(N'(1) << 10);
    pulse(N'(1) << 10);
    pulse(N'(1) << 12);
    do_load(); do_load();

    // R5 only the selected cell is cleared
    pulse(N'(3) << 20);
    do_load();
    #2;
    check("R5 neighbour kept", {15'd0, out_valid, out_word}, {15'd0, 1'b1, 8'd21, mts[21]});
    do_load();

    // R8 held line flags once
    @(negedge clk);
    v = ts_in;
    hit_in[33] = 1'b1;
    repeat (3) @(negedge clk);
    mflag[33] = 1; mts[33] = v + 8'd2;
    do_load();
    repeat (5) @(negedge clk);
    #2;
    check("R8 held line no reflag", {31'd0, out_valid}, 0);
    hit_in = '0;
    pulse(N'(1) << 33);
    do_load();

    // R1 reset drops pending hits
    pulse(N'(1) << 30);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    clear_model();
    #2;
    check("R1 reset clears pending", {15'd0, out_valid, out_word}, 0);
    do_load();

    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule